// File: doc/BRIEF.md
# Branch, Call and Stack Sequencer

This block carries out the control-transfer and stack operations of an 8-bit processor that has a 16-bit program counter and a 16-bit stack pointer. The decoder hands it one operation together with a condition selector, the current flag byte, and the register values involved. The block then runs the byte-wide memory reads and writes that the operation needs. It ends with a one-cycle completion pulse that carries the new program counter, the new stack pointer, and any word to be written back to a register pair.

Jumps and calls take their two-byte target from memory at the program counter, low byte first. A conditional transfer whose condition fails touches no memory and only steps past the operand. Words on the stack are little-endian and the stack grows downward. Two special forms are included: an accumulator-plus-flags push and pop, and a swap of HL with the word on top of the stack. Operand fetch beyond the two address bytes and all arithmetic belong to neighbouring blocks.

Top module: `xfer_stack_unit`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all 0.
- R2: The condition code `cond` selects one of eight tests on `flags`, where sign is bit 7, zero is bit 6, parity is bit 2 (1 means even) and carry is bit 0. The codes are 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity odd, 5 parity even, 6 sign clear and 7 sign set. When `cond_en` is 0, a jump, call or return is unconditional.
- R3: Jump (op 0), when taken, reads `pc_in` and then `pc_in+1`, and `pc_out` is {second byte, first byte}. When not taken, it makes no memory access and `pc_out` = `pc_in+2`.
- R4: Call (op 1), when taken, reads its target the same way as a jump. It then writes `pc_in+2`, low byte at `sp_in-2` and high byte at `sp_in-1`, and gives `sp_out` = `sp_in-2`. When not taken, it makes no access, gives `pc_out` = `pc_in+2`, and leaves the stack pointer unchanged.
- R5: Return (op 2), when taken, reads `sp_in` and `sp_in+1` into `pc_out` and gives `sp_out` = `sp_in+2`. When not taken, it makes no access and `pc_out`, `sp_out` equal `pc_in`, `sp_in`.
- R6: Restart (op 3) pushes `pc_in` like a call and gives `pc_out` = `cond`×8.
- R7: Push (op 4) writes `pair_in`, low byte at `sp_in-2` and high byte at `sp_in-1`, and gives `sp_out` = `sp_in-2`. Pop (op 6) reads `sp_in` (low) and `sp_in+1` (high) into `pair_out` and gives `sp_out` = `sp_in+2`. For ops that return no word, `pair_out` is 0.
- R8: Flags push (op 5) writes `flags` at `sp_in-2` and `acc` at `sp_in-1`. Flags pop (op 7) returns {byte at `sp_in+1`, byte at `sp_in`}, with bit 1 of the low byte forced to 1 and bit 3 forced to 0.
- R9: Stack-top swap (op 8) reads `sp_in` and `sp_in+1`, then writes `hl_in` low and high to those same addresses. `pair_out` is the old stack word and `sp_out` = `sp_in`.
- R10: PC-from-HL (op 9) gives `pc_out` = `hl_in`, and SP-from-HL (op 10) gives `sp_out` = `hl_in`. Neither touches memory.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_rdy` is seen. Each cycle with `mem_req` and `mem_rdy` both high moves exactly one byte. All reads of an operation come before all of its writes.
- R12: `done` is high for exactly one cycle after the last access. A `start` while `busy` is ignored. Op codes 11 to 15 complete with no access, unchanged `pc_out`/`sp_out`, and `pair_out` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 4 | Operation code |
| cond_en | input | 1 | 1 makes jump/call/return conditional |
| cond | input | 3 | Condition code, or restart vector index |
| flags | input | 8 | Current flag byte |
| acc | input | 8 | Accumulator, for flags push |
| pc_in | input | 16 | Address of the first operand byte |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | HL register pair |
| pair_in | input | 16 | Register pair to push |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter, valid with done |
| sp_out | output | 16 | New stack pointer, valid with done |
| pair_out | output | 16 | Word for a register pair, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rdy | input | 1 | Access accepted this cycle |

## Verification
The hardest situation to reach from the ports is a four-access stack-top swap or taken call in which `mem_rdy` stalls between the two bytes of a word or between the read and write phases. The bench therefore drives `mem_rdy` from a seeded random source, so stalls land at every beat position across hundreds of mixed operations. Wrap-around of the stack pointer and program counter near 0000 and FFFF, and a `start` raised while the block is busy, are forced as directed cases.

// File: rtl/xfer_pkg.sv
// Shared constants and types for the branch/call/stack sequencer.
// Assumes an address of exactly two bytes.
package xfer_pkg;
    localparam int BYTE_W = 8;

    // Operation codes delivered by the decoder
    localparam logic [3:0] XOP_JUMP     = 4'd0;
    localparam logic [3:0] XOP_CALL     = 4'd1;
    localparam logic [3:0] XOP_RET      = 4'd2;
    localparam logic [3:0] XOP_RST      = 4'd3;
    localparam logic [3:0] XOP_PUSH     = 4'd4;
    localparam logic [3:0] XOP_PUSH_AF  = 4'd5;
    localparam logic [3:0] XOP_POP      = 4'd6;
    localparam logic [3:0] XOP_POP_AF   = 4'd7;
    localparam logic [3:0] XOP_XCHG_TOP = 4'd8;
    localparam logic [3:0] XOP_PC_HL    = 4'd9;
    localparam logic [3:0] XOP_SP_HL    = 4'd10;

    // Flag byte bit positions
    localparam int FL_CARRY = 0;
    localparam int FL_ONE   = 1;
    localparam int FL_PAR   = 2;
    localparam int FL_ZERO3 = 3;
    localparam int FL_ZERO  = 6;
    localparam int FL_SIGN  = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEC, ST_RD, ST_WR, ST_FIN
    } seq_state_e;
endpackage

// File: rtl/xfer_cond.sv
// Condition evaluator: code bits [2:1] pick a flag, bit 0 picks its polarity.
// Assumes the flag layout given in xfer_pkg.
module xfer_cond
    import xfer_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic [2:0]    sel,
    input  logic [BW-1:0] flags,
    output logic          holds
);
    logic flag_bit;

    // Pick the tested flag and apply polarity
    always_comb begin
        case (sel[2:1])
            2'd0:    flag_bit = flags[FL_ZERO];
            2'd1:    flag_bit = flags[FL_CARRY];
            2'd2:    flag_bit = flags[FL_PAR];
            default: flag_bit = flags[FL_SIGN];
        endcase
        holds = sel[0] ? flag_bit : ~flag_bit;
    end
endmodule

// File: rtl/xfer_plan.sv
// Operation planner: from the latched operation, decides which two-byte
// read and/or write the sequencer must run, their base addresses, the word
// to store, and the final PC/SP/pair results. Purely combinational.
// Assumes rd_word holds the read word once the read phase has finished.
module xfer_plan
    import xfer_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic [3:0]      op,
    input  logic            taken,
    input  logic [2:0]      vec,
    input  logic [BW-1:0]   flags,
    input  logic [BW-1:0]   acc,
    input  logic [2*BW-1:0] pc,
    input  logic [2*BW-1:0] sp,
    input  logic [2*BW-1:0] hl,
    input  logic [2*BW-1:0] pair,
    input  logic [2*BW-1:0] rd_word,
    output logic            need_rd,
    output logic            need_wr,
    output logic [2*BW-1:0] rd_base,
    output logic [2*BW-1:0] wr_base,
    output logic [2*BW-1:0] wr_word,
    output logic [2*BW-1:0] pc_res,
    output logic [2*BW-1:0] sp_res,
    output logic [2*BW-1:0] pair_res
);
    localparam int AW = 2 * BW;
    localparam int VEC_SHIFT = 3;
    localparam logic [AW-1:0] STEP = AW'(2);

    logic [BW-1:0] flags_fixed;

    // Normalise a popped flag byte
    always_comb begin
        flags_fixed = rd_word[BW-1:0];
        flags_fixed[FL_ONE]   = 1'b1;
        flags_fixed[FL_ZERO3] = 1'b0;
    end

    // Per-operation access plan and results
    always_comb begin
        need_rd  = 1'b0;
        need_wr  = 1'b0;
        rd_base  = sp;
        wr_base  = sp - STEP;
        wr_word  = '0;
        pc_res   = pc;
        sp_res   = sp;
        pair_res = '0;
        case (op)
            XOP_JUMP: begin
                if (taken) begin
                    need_rd = 1'b1;
                    rd_base = pc;
                    pc_res  = rd_word;
                end else begin
                    pc_res = pc + STEP;
                end
            end
            XOP_CALL: begin
                if (taken) begin
                    need_rd = 1'b1;
                    rd_base = pc;
                    need_wr = 1'b1;
                    wr_word = pc + STEP;
                    pc_res  = rd_word;
                    sp_res  = sp - STEP;
                end else begin
                    pc_res = pc + STEP;
                end
            end
            XOP_RET: begin
                if (taken) begin
                    need_rd = 1'b1;
                    pc_res  = rd_word;
                    sp_res  = sp + STEP;
                end
            end
            XOP_RST: begin
                need_wr = 1'b1;
                wr_word = pc;
                pc_res  = AW'(vec) << VEC_SHIFT;
                sp_res  = sp - STEP;
            end
            XOP_PUSH: begin
                need_wr = 1'b1;
                wr_word = pair;
                sp_res  = sp - STEP;
            end
            XOP_PUSH_AF: begin
                need_wr = 1'b1;
                wr_word = {acc, flags};
                sp_res  = sp - STEP;
            end
            XOP_POP: begin
                need_rd  = 1'b1;
                pair_res = rd_word;
                sp_res   = sp + STEP;
            end
            XOP_POP_AF: begin
                need_rd  = 1'b1;
                pair_res = {rd_word[AW-1:BW], flags_fixed};
                sp_res   = sp + STEP;
            end
            XOP_XCHG_TOP: begin
                need_rd  = 1'b1;
                need_wr  = 1'b1;
                wr_base  = sp;
                wr_word  = hl;
                pair_res = rd_word;
            end
            XOP_PC_HL: pc_res = hl;
            XOP_SP_HL: sp_res = hl;
            default: ;
        endcase
    end
endmodule

// File: rtl/xfer_stack_unit.sv
// Branch, call and stack sequencer. Latches an operation on start, runs
// up to one two-byte read followed by one two-byte write over a byte-wide
// memory port with a ready handshake, then pulses done with the results.
// Assumes the memory holds no request it has not acknowledged with mem_rdy.
module xfer_stack_unit
    import xfer_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic            cond_en,
    input  logic [2:0]      cond,
    input  logic [BW-1:0]   flags,
    input  logic [BW-1:0]   acc,
    input  logic [2*BW-1:0] pc_in,
    input  logic [2*BW-1:0] sp_in,
    input  logic [2*BW-1:0] hl_in,
    input  logic [2*BW-1:0] pair_in,
    output logic            busy,
    output logic            done,
    output logic [2*BW-1:0] pc_out,
    output logic [2*BW-1:0] sp_out,
    output logic [2*BW-1:0] pair_out,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*BW-1:0] mem_addr,
    output logic [BW-1:0]   mem_wdata,
    input  logic [BW-1:0]   mem_rdata,
    input  logic            mem_rdy
);
    localparam int AW = 2 * BW;

    seq_state_e    state;
    logic          beat;
    logic [3:0]    op_q;
    logic          cen_q;
    logic [2:0]    cond_q;
    logic [BW-1:0] flags_q, acc_q;
    logic [AW-1:0] pc_q, sp_q, hl_q, pair_q, rd_word;

    logic          holds, taken;
    logic          need_rd, need_wr;
    logic [AW-1:0] rd_base, wr_base, wr_word;

    xfer_cond #(.BW(BW)) u_cond (
        .sel   (cond_q),
        .flags (flags_q),
        .holds (holds)
    );

    assign taken = !cen_q || holds;

    xfer_plan #(.BW(BW)) u_plan (
        .op       (op_q),
        .taken    (taken),
        .vec      (cond_q),
        .flags    (flags_q),
        .acc      (acc_q),
        .pc       (pc_q),
        .sp       (sp_q),
        .hl       (hl_q),
        .pair     (pair_q),
        .rd_word  (rd_word),
        .need_rd  (need_rd),
        .need_wr  (need_wr),
        .rd_base  (rd_base),
        .wr_base  (wr_base),
        .wr_word  (wr_word),
        .pc_res   (pc_out),
        .sp_res   (sp_out),
        .pair_res (pair_out)
    );

    // Sequencer: latch, decide, read beats, write beats, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            beat    <= 1'b0;
            op_q    <= '0;
            cen_q   <= 1'b0;
            cond_q  <= '0;
            flags_q <= '0;
            acc_q   <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            hl_q    <= '0;
            pair_q  <= '0;
            rd_word <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op;
                        cen_q   <= cond_en;
                        cond_q  <= cond;
                        flags_q <= flags;
                        acc_q   <= acc;
                        pc_q    <= pc_in;
                        sp_q    <= sp_in;
                        hl_q    <= hl_in;
                        pair_q  <= pair_in;
                        rd_word <= '0;
                        beat    <= 1'b0;
                        state   <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    state <= need_rd ? ST_RD : (need_wr ? ST_WR : ST_FIN);
                end
                ST_RD: begin
                    if (mem_rdy) begin
                        if (beat) begin
                            rd_word[AW-1:BW] <= mem_rdata;
                            state <= need_wr ? ST_WR : ST_FIN;
                        end else begin
                            rd_word[BW-1:0] <= mem_rdata;
                        end
                        beat <= ~beat;
                    end
                end
                ST_WR: begin
                    if (mem_rdy) begin
                        if (beat) state <= ST_FIN;
                        beat <= ~beat;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive from sequencer state
    always_comb begin
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = '0;
        mem_wdata = '0;
        if (state == ST_RD) mem_addr = rd_base + AW'(beat);
        if (state == ST_WR) begin
            mem_addr  = wr_base + AW'(beat);
            mem_wdata = beat ? wr_word[AW-1:BW] : wr_word[BW-1:0];
        end
    end

    // Status outputs
    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

    // R11: an unacknowledged request holds its address, direction and data
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata));

    // R7: the second byte of a word follows at the next address, same direction
    p_word_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rdy && !beat |=> mem_req && (mem_we == $past(mem_we))
                                      && (mem_addr == $past(mem_addr) + AW'(1)));

    // R11: once writing starts, no read follows within the operation
    p_no_read_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |=> !(mem_req && !mem_we));

    // R12: done lasts one cycle and returns the block to idle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R2: a failed condition on a transfer produces no memory traffic
    p_untaken_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC) && !taken &&
        (op_q == XOP_JUMP || op_q == XOP_CALL || op_q == XOP_RET) |=> !mem_req);
endmodule

// File: tb/xfer_stack_unit_tb.sv
module xfer_stack_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic        cond_en = 1'b0;
    logic [2:0]  cond = '0;
    logic [7:0]  flags = '0, acc = '0;
    logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0, pair_in = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] pc_out, sp_out, pair_out, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_rdy = 1'b1;
    bit          rdy_random = 1'b0;

    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    xfer_stack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
        .cond(cond), .flags(flags), .acc(acc), .pc_in(pc_in), .sp_in(sp_in),
        .hl_in(hl_in), .pair_in(pair_in), .busy(busy), .done(done),
        .pc_out(pc_out), .sp_out(sp_out), .pair_out(pair_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    // Memory content as a function of the address
    function automatic logic [7:0] mfn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign mem_rdata = mfn(mem_addr);

    always @(negedge clk) mem_rdy <= rdy_random ? (($urandom % 4) != 0) : 1'b1;

    // Access log
    logic [15:0] lg_a [0:15];
    logic        lg_w [0:15];
    logic [7:0]  lg_d [0:15];
    int unsigned ln = 0;
    always @(posedge clk) begin
        if (mem_req && mem_rdy) begin
            lg_a[ln & 15] <= mem_addr;
            lg_w[ln & 15] <= mem_we;
            lg_d[ln & 15] <= mem_we ? mem_wdata : mem_rdata;
            ln <= ln + 1;
        end
    end

    // Expected accesses
    logic [15:0] ex_a [0:3];
    logic        ex_w [0:3];
    logic [7:0]  ex_d [0:3];
    int          ex_n;

    function automatic void add_exp(input logic [15:0] a, input logic w, input logic [7:0] d);
        ex_a[ex_n] = a; ex_w[ex_n] = w; ex_d[ex_n] = d; ex_n++;
    endfunction

    function automatic void add_read(input logic [15:0] a);
        add_exp(a, 1'b0, mfn(a));
        add_exp(a + 16'd1, 1'b0, mfn(a + 16'd1));
    endfunction

    function automatic void add_write(input logic [15:0] a, input logic [15:0] w);
        add_exp(a, 1'b1, w[7:0]);
        add_exp(a + 16'd1, 1'b1, w[15:8]);
    endfunction

    function automatic void chk(input bit ok, input string req, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endfunction

    task automatic run_op(input string req, input logic [3:0] o, input logic ce,
                          input logic [2:0] cc, input logic [7:0] fl, input logic [7:0] ac,
                          input logic [15:0] pc, input logic [15:0] sp,
                          input logic [15:0] hl, input logic [15:0] pr, input bit poke);
        logic fb, tk;
        logic [15:0] epc, esp, epr, w;
        int unsigned base;
        int waited;
        case (cc[2:1])
            2'd0: fb = fl[6];
            2'd1: fb = fl[0];
            2'd2: fb = fl[2];
            default: fb = fl[7];
        endcase
        tk = !ce || (cc[0] ? fb : !fb);
        epc = pc; esp = sp; epr = 16'h0; ex_n = 0;
        case (o)
            4'd0: if (tk) begin add_read(pc); epc = {mfn(pc + 16'd1), mfn(pc)}; end
                  else epc = pc + 16'd2;
            4'd1: if (tk) begin
                      add_read(pc); add_write(sp - 16'd2, pc + 16'd2);
                      epc = {mfn(pc + 16'd1), mfn(pc)}; esp = sp - 16'd2;
                  end else epc = pc + 16'd2;
            4'd2: if (tk) begin add_read(sp); epc = {mfn(sp + 16'd1), mfn(sp)}; esp = sp + 16'd2; end
            4'd3: begin add_write(sp - 16'd2, pc); epc = {10'd0, cc, 3'd0}; esp = sp - 16'd2; end
            4'd4: begin add_write(sp - 16'd2, pr); esp = sp - 16'd2; end
            4'd5: begin add_write(sp - 16'd2, {ac, fl}); esp = sp - 16'd2; end
            4'd6: begin add_read(sp); epr = {mfn(sp + 16'd1), mfn(sp)}; esp = sp + 16'd2; end
            4'd7: begin
                      add_read(sp); w = {mfn(sp + 16'd1), mfn(sp)};
                      epr = {w[15:8], (w[7:0] | 8'h02) & 8'hF7}; esp = sp + 16'd2;
                  end
            4'd8: begin add_read(sp); add_write(sp, hl); epr = {mfn(sp + 16'd1), mfn(sp)}; end
            4'd9: epc = hl;
            4'd10: esp = hl;
            default: ;
        endcase
        @(negedge clk);
        base = ln;
        op = o; cond_en = ce; cond = cc; flags = fl; acc = ac;
        pc_in = pc; sp_in = sp; hl_in = hl; pair_in = pr; start = 1'b1;
        @(negedge clk);
        start = poke;
        if (poke) begin op = 4'd9; hl_in = ~hl; end
        waited = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            waited++;
        end while (!done && waited < 200);
        chk(done == 1'b1, req, "done seen", {31'd0, done}, 32'd1);
        chk(pc_out == epc, req, "pc_out", {16'd0, pc_out}, {16'd0, epc});
        chk(sp_out == esp, req, "sp_out", {16'd0, sp_out}, {16'd0, esp});
        chk(pair_out == epr, req, "pair_out", {16'd0, pair_out}, {16'd0, epr});
        chk((ln - base) == ex_n, req, "access count", ln - base, ex_n);
        for (int i = 0; i < ex_n && i < int'(ln - base); i++) begin
            chk(lg_a[(base + i) & 15] == ex_a[i], req, "access addr",
                {16'd0, lg_a[(base + i) & 15]}, {16'd0, ex_a[i]});
            chk(lg_w[(base + i) & 15] == ex_w[i], req, "access dir",
                {31'd0, lg_w[(base + i) & 15]}, {31'd0, ex_w[i]});
            chk(lg_d[(base + i) & 15] == ex_d[i], req, "access data",
                {24'd0, lg_d[(base + i) & 15]}, {24'd0, ex_d[i]});
        end
        @(negedge clk);
        chk(done == 1'b0, "R12", "done pulse width", {31'd0, done}, 32'd0);
        if (poke) begin
            repeat (2) @(negedge clk);
            chk(busy == 1'b0, "R12", "start while busy ignored", {31'd0, busy}, 32'd0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0B17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "idle after reset",
            {29'd0, busy, done, mem_req}, 32'd0);

        // R2 R3: every condition, once true and once false
        for (int c = 0; c < 8; c++) begin
            run_op("R2", 4'd0, 1'b1, 3'(c), 8'hC5, 8'h00, 16'h1200, 16'h8000, 16'h0, 16'h0, 1'b0);
            run_op("R2", 4'd0, 1'b1, 3'(c), 8'h00, 8'h00, 16'h1200, 16'h8000, 16'h0, 16'h0, 1'b0);
        end
        run_op("R3", 4'd0, 1'b0, 3'd1, 8'h00, 8'h00, 16'hFFFF, 16'h8000, 16'h0, 16'h0, 1'b0);
        run_op("R4", 4'd1, 1'b1, 3'd3, 8'h01, 8'h00, 16'h4321, 16'h0001, 16'h0, 16'h0, 1'b0);
        run_op("R4", 4'd1, 1'b1, 3'd3, 8'h00, 8'h00, 16'h4321, 16'h0001, 16'h0, 16'h0, 1'b0);
        run_op("R5", 4'd2, 1'b1, 3'd6, 8'h80, 8'h00, 16'h0100, 16'hFFFF, 16'h0, 16'h0, 1'b0);
        run_op("R6", 4'd3, 1'b0, 3'd7, 8'h00, 8'h00, 16'hABCD, 16'h2000, 16'h0, 16'h0, 1'b0);
        run_op("R7", 4'd4, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0, 16'h0000, 16'h0, 16'hBEEF, 1'b0);
        run_op("R7", 4'd6, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0, 16'hFFFE, 16'h0, 16'h0, 1'b0);
        run_op("R8", 4'd5, 1'b0, 3'd0, 8'hD7, 8'h5A, 16'h0, 16'h3000, 16'h0, 16'h0, 1'b0);
        run_op("R8", 4'd7, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0, 16'h3434, 16'h0, 16'h0, 1'b0);
        run_op("R9", 4'd8, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0, 16'h7FFF, 16'hCAFE, 16'h0, 1'b0);
        run_op("R10", 4'd9, 1'b0, 3'd0, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h9876, 16'h0, 1'b0);
        run_op("R10", 4'd10, 1'b0, 3'd0, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h9876, 16'h0, 1'b0);
        run_op("R12", 4'd13, 1'b0, 3'd0, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h9876, 16'h0, 1'b0);
        run_op("R12", 4'd8, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0, 16'h4000, 16'h1357, 16'h0, 1'b1);
        run_op("R12", 4'd10, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0, 16'h4000, 16'h1357, 16'h0, 1'b1);

        // R11: random ready stalls with mixed random operations
        rdy_random = 1'b1;
        for (int n = 0; n < 400; n++) begin
            run_op("R11", 4'($urandom % 12), 1'($urandom), 3'($urandom), 8'($urandom),
                   8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                   16'($urandom), 1'(($urandom % 8) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule